// File: doc/BRIEF.md
# Completion Event Ring Writer

This block keeps the producer side of a circular ring of completion event records for one DMA channel. Each time a transfer finishes, the channel presents a completion strobe carrying a 4-bit completion code, a 4-bit error-info value and the transfer's config word. The block formats one record, writes it into a local record memory at the current write pointer, advances the pointer by one 16-byte record slot, and pulses an end-of-block event when the transfer asked for one.

Software owns a small register port. Through it, it programs the ring length in bytes, reads back the hardware write pointer, and posts its read offset to a doorbell once it has consumed records. The doorbell is what frees slots. One slot is always kept empty, so the ring is full when advancing the write pointer would land on the posted read offset. While the ring is full, an incoming completion is held off and a busy output is raised until space is returned.

Top module: `ev_ring_writer`

## Requirements
- R1: After reset, the ring length reads back `DEF_LEN` (128) and the write pointer reads back 0. The read offset reads back 0 and no record write or event is presented.
- R2: A completion that is accepted (`cmp_valid` high and `busy` low at a rising edge) presents exactly one record write with `rec_we` high in the following cycle. `rec_addr` equals the write pointer byte offset from before the advance.
- R3: The record word carries the completion code in bits 31:28 and the error info in bits 27:24, and all other bits are zero. Code 1 denotes success and code 4 denotes error, and both pass through unchanged.
- R4: Each accepted completion advances the write pointer by 16, and every record address is a multiple of 16.
- R5: When the advanced write pointer would reach or exceed the programmed ring length, it wraps to 0.
- R6: The ring is full when the advanced (wrapped) write pointer equals the read offset. While full, a pending completion raises `busy`, no record is written and the write pointer holds.
- R7: A doorbell write of a new read offset frees space, and a stalled completion is accepted at the first edge at which the ring is no longer full.
- R8: `eob` pulses together with the record write only when bit 16 of that completion's config word is set.
- R9: Register map on `reg_addr`: 0 is the ring length (read/write), 1 is the write pointer (read-only; writes have no effect), and 2 is the doorbell read offset (read/write). Reads are combinational.
- R10: Records are written in exactly the order in which completions were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low channel reset |
| cmp_valid | input | 1 | Completion strobe, held until accepted |
| cmp_code | input | 4 | Completion code |
| cmp_info | input | 4 | Error info |
| cmp_cfg | input | 32 | Transfer config word; bit 16 requests an end-of-block event |
| busy | output | 1 | Completion pending while ring is full |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | PTR_W | Register write data |
| reg_rdata | output | PTR_W | Register read data |
| rec_we | output | 1 | Record write enable |
| rec_addr | output | PTR_W | Record byte offset in the ring |
| rec_data | output | 32 | Record first word |
| eob | output | 1 | End-of-block event pulse |

## Verification
A record is due one cycle after the edge that accepts its completion, and the write-pointer readback changes at that same edge. `busy` is combinational and is valid in the cycle the strobe is presented. The driver applies inputs on falling edges and decides on acceptance from `busy` just before the next rising edge, then pushes the expected record into a queue. A monitor pops that queue on the falling edge one cycle later and compares it against any record write or event that appears, so a stray or missing record surfaces at the exact cycle it should have occurred. Register reads are sampled shortly after a falling edge, once the combinational mux has settled.

// File: rtl/ev_ring_pkg.sv
// Shared constants and types for the completion event ring writer.
package ev_ring_pkg;
    localparam int REC_BYTES  = 16;   // bytes per event record
    localparam int REC_W      = 32;   // width of the record's first word
    localparam int CODE_LSB   = 28;   // completion code field position
    localparam int INFO_LSB   = 24;   // error-info field position
    localparam int EOB_REQ_BIT = 16;  // config bit requesting an end-of-block event

    localparam logic [3:0] CODE_OK  = 4'd1;
    localparam logic [3:0] CODE_ERR = 4'd4;

    typedef enum logic [1:0] {
        RSEL_LEN  = 2'd0,
        RSEL_WPTR = 2'd1,
        RSEL_DBL  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/evr_regs.sv
// Register port: ring length, write pointer readback, consumer doorbell.
// Assumes software writes only multiples of the record size.
module evr_regs
    import ev_ring_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int DEF_LEN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [PTR_W-1:0] reg_wdata,
    input  logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] ring_len,
    output logic [PTR_W-1:0] rd_off,
    output logic [PTR_W-1:0] reg_rdata
);
    // Holds the programmed length and the consumer's posted read offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_len <= PTR_W'(DEF_LEN);
            rd_off   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == RSEL_LEN) ring_len <= reg_wdata;
            if (reg_addr == RSEL_DBL) rd_off   <= reg_wdata;
        end
    end

    // Combinational readback mux.
    always_comb begin
        unique case (reg_addr)
            RSEL_LEN:  reg_rdata = ring_len;
            RSEL_WPTR: reg_rdata = wptr;
            RSEL_DBL:  reg_rdata = rd_off;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evr_wptr.sv
// Write pointer: advances one record slot per accepted completion, wraps
// at the ring length and flags full when the next slot is the read offset.
module evr_wptr
    import ev_ring_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [PTR_W-1:0] ring_len,
    input  logic [PTR_W-1:0] rd_off,
    output logic [PTR_W-1:0] wptr,
    output logic             full
);
    localparam int SUM_W = PTR_W + 1;

    logic [SUM_W-1:0] step_sum;
    logic [PTR_W-1:0] next_ptr;

    // Next slot offset with wrap at the programmed length.
    always_comb begin
        step_sum = {1'b0, wptr} + SUM_W'(REC_BYTES);
        next_ptr = (step_sum >= {1'b0, ring_len}) ? '0 : step_sum[PTR_W-1:0];
        full     = (next_ptr == rd_off);
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)       wptr <= '0;
        else if (advance) wptr <= next_ptr;
    end
endmodule

// File: rtl/evr_rec_out.sv
// Record formatter and output register: one registered write per accepted
// completion, with an end-of-block pulse when the config word asks for it.
module evr_rec_out
    import ev_ring_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [PTR_W-1:0] slot,
    input  logic [3:0]       code,
    input  logic [3:0]       info,
    input  logic             eob_req,
    output logic             rec_we,
    output logic [PTR_W-1:0] rec_addr,
    output logic [REC_W-1:0] rec_data,
    output logic             eob
);
    logic [REC_W-1:0] word;

    // Places code and info in their fields; all other bits are zero.
    always_comb begin
        word = '0;
        word[CODE_LSB +: 4] = code;
        word[INFO_LSB +: 4] = info;
    end

    // Registers the record write and the event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_we   <= 1'b0;
            eob      <= 1'b0;
            rec_addr <= '0;
            rec_data <= '0;
        end else begin
            rec_we <= take;
            eob    <= take && eob_req;
            if (take) begin
                rec_addr <= slot;
                rec_data <= word;
            end
        end
    end
endmodule

// File: rtl/ev_ring_writer.sv
// Top: completion event ring writer. Accepts a completion when the ring is
// not full, writes one record the next cycle, advances the write pointer.
// Assumes the producer holds cmp_valid and its fields stable while busy.
module ev_ring_writer
    import ev_ring_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int DEF_LEN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [3:0]       cmp_code,
    input  logic [3:0]       cmp_info,
    input  logic [31:0]      cmp_cfg,
    output logic             busy,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [PTR_W-1:0] reg_wdata,
    output logic [PTR_W-1:0] reg_rdata,
    output logic             rec_we,
    output logic [PTR_W-1:0] rec_addr,
    output logic [REC_W-1:0] rec_data,
    output logic             eob
);
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] ring_len;
    logic [PTR_W-1:0] rd_off;
    logic             full;
    logic             accept;

    // Acceptance and stall decision.
    always_comb begin
        busy   = cmp_valid && full;
        accept = cmp_valid && !full;
    end

    evr_regs #(.PTR_W(PTR_W), .DEF_LEN(DEF_LEN)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wptr(wptr), .ring_len(ring_len),
        .rd_off(rd_off), .reg_rdata(reg_rdata)
    );

    evr_wptr #(.PTR_W(PTR_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .advance(accept), .ring_len(ring_len),
        .rd_off(rd_off), .wptr(wptr), .full(full)
    );

    evr_rec_out #(.PTR_W(PTR_W)) u_out (
        .clk(clk), .rst_n(rst_n), .take(accept), .slot(wptr),
        .code(cmp_code), .info(cmp_info), .eob_req(cmp_cfg[EOB_REQ_BIT]),
        .rec_we(rec_we), .rec_addr(rec_addr), .rec_data(rec_data), .eob(eob)
    );
endmodule

// File: rtl/ev_ring_writer_chk.sv
// Checker for the ring writer, bound to every instance of the top.
module ev_ring_writer_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmp_valid,
    input logic             busy,
    input logic             rec_we,
    input logic [PTR_W-1:0] rec_addr,
    input logic             eob,
    input logic [PTR_W-1:0] wptr
);
    AST_ACCEPT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !busy) |=> rec_we); // R2
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rec_we); // R6
    AST_BUSY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cmp_valid); // R6
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_valid && !busy) |=> $stable(wptr)); // R6
    AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rec_we |-> (rec_addr[3:0] == 4'd0)); // R4
    AST_EOB_WITH_REC: assert property (@(posedge clk) disable iff (!rst_n)
        eob |-> rec_we); // R8
endmodule

bind ev_ring_writer ev_ring_writer_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .busy(busy),
    .rec_we(rec_we), .rec_addr(rec_addr), .eob(eob), .wptr(wptr)
);

// File: tb/ev_ring_writer_bench.sv
module ev_ring_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PTR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_valid = 1'b0;
    logic [3:0]       cmp_code = '0;
    logic [3:0]       cmp_info = '0;
    logic [31:0]      cmp_cfg = '0;
    logic             busy;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = '0;
    logic [PTR_W-1:0] reg_wdata = '0;
    logic [PTR_W-1:0] reg_rdata;
    logic             rec_we;
    logic [PTR_W-1:0] rec_addr;
    logic [31:0]      rec_data;
    logic             eob;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // bench model
    int m_wptr = 0;
    int m_len  = 128;
    int m_rd   = 0;

    typedef struct { int addr; logic [31:0] data; logic ev; } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ev_ring_writer #(.PTR_W(PTR_W), .DEF_LEN(128)) u_ev_ring_writer (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_code(cmp_code),
        .cmp_info(cmp_info), .cmp_cfg(cmp_cfg), .busy(busy), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rec_we(rec_we), .rec_addr(rec_addr), .rec_data(rec_data), .eob(eob)
    );

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int next_slot(input int p);
        return (p + 16 >= m_len) ? 0 : p + 16;
    endfunction

    // Driver: presents one completion, waits while stalled, records expectation.
    task automatic send(input logic [3:0] code, input logic [3:0] info, input bit ev);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_code = code; cmp_info = info;
        cmp_cfg = ev ? 32'h0001_00A5 : 32'h0000_00A5;
        #1;
        while (busy) begin
            @(negedge clk);
            #1;
        end
        sb.push_back('{m_wptr, {code, info, 24'h0}, ev});
        m_wptr = next_slot(m_wptr);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input int v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = PTR_W'(v);
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) m_len = v;
        if (a == 2'd2) m_rd = v;
    endtask

    task automatic reg_read(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // Monitor: pops the scoreboard when a record appears (R2, R3, R8, R10).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rec_we) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected record", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check("R2/R10 record addr", rec_addr, e.addr);
                    check("R3 record data", rec_data, e.data);
                    check("R8 eob", eob, e.ev);
                end
            end else if (eob) begin
                check("R8 eob without record", 1, 0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 check("R1 rec_we", rec_we, 0);
        reg_read(2'd0, 128, "R1 length");
        reg_read(2'd1, 0, "R1 wptr");
        reg_read(2'd2, 0, "R1 read offset");

        // R3 success/error codes, R8 eob choice, R4 advance
        send(4'd1, 4'd0, 1'b1);
        send(4'd4, 4'd9, 1'b0);
        send(4'd1, 4'd15, 1'b1);
        @(negedge clk);
        reg_read(2'd1, 48, "R4 wptr after three");

        // R9 write to wptr has no effect
        reg_write(2'd1, 80);
        reg_read(2'd1, 48, "R9 wptr read-only");

        // Fill to full: 7 slots of 8 (R6)
        for (int i = 0; i < 4; i++) send(4'd1, 4'(i), i[0]);
        @(negedge clk);
        reg_read(2'd1, 112, "R4 wptr at 112");
        fork
            send(4'd4, 4'd3, 1'b1);
            begin
                repeat (3) @(negedge clk);
                #1 check("R6 busy while full", busy, 1);
                reg_read(2'd1, 112, "R6 wptr holds");
                reg_write(2'd2, 32);   // R7 doorbell frees space
            end
        join
        @(negedge clk);
        reg_read(2'd1, 0, "R5 wrap at 128");
        reg_read(2'd2, 32, "R9 doorbell readback");

        // Shorter ring: length 64 (R5, R9)
        reg_write(2'd2, 0);
        reg_write(2'd0, 64);
        reg_read(2'd0, 64, "R9 length readback");
        send(4'd1, 4'd1, 1'b0);
        send(4'd1, 4'd2, 1'b1);
        send(4'd4, 4'd7, 1'b0);
        @(negedge clk);
        reg_read(2'd1, 48, "R4 wptr 48 in short ring");
        fork
            send(4'd1, 4'd5, 1'b1);
            begin
                repeat (2) @(negedge clk);
                #1 check("R6 busy short ring", busy, 1);
                reg_write(2'd2, 48);   // R7
            end
        join
        @(negedge clk);
        reg_read(2'd1, 0, "R5 wrap at 64");
        repeat (2) @(negedge clk);
        check("R10 all records seen", sb.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule